// File: doc/BRIEF.md
# Three-Mode 16-Bit Timer/Counter

This block is a 16-bit timer/counter for a microcontroller peripheral set. One counter can work in three modes. In capture mode it free-runs and can record its value on an external trigger. In auto-reload mode it restarts from a programmable value. In baud-generator mode it produces a periodic single-clock tick that a serial port can use as its bit clock. The count advances on a machine-cycle tick or on falling edges at an external count pin. A second external pin acts as the capture/reload trigger.

Software programs the block through a byte-wide write port that reaches five registers: the two count bytes, the two bytes of the shared capture/reload pair, and a control register. The full count and the capture/reload pair are brought out for read-back. An overflow flag and a trigger flag are held until software clears them.

Top module: `t16_timer`

## Requirements
- R1: After a synchronous reset, the count, the capture/reload pair, both flags and the baud tick are all zero.
- R2: When `wr_en_i` is high, `wr_data_i` is written to the register that `wr_sel_i` selects: 0 is the count low byte, 1 the count high byte, 2 the pair low byte, 3 the pair high byte, 4 control. The control bits are: bit0 run, bit1 external count select, bit2 trigger enable, bit3 reload mode (0 = capture mode), bit4 baud mode (overrides bit3), bit6 trigger flag, bit7 overflow flag.
- R3: The count rises by one for each `tick_i` pulse in capture or reload mode when run is set and the external count select is clear.
- R4: While run is clear, the count holds its value.
- R5: In capture mode, a step from FFFFh gives 0000h and sets the overflow flag.
- R6: In reload mode, a step from FFFFh loads the count from the capture/reload pair and sets the overflow flag.
- R7: When the external count select is set, the count rises once for each falling edge on `ext_cnt_i`. An edge is the synchronized pin seen high at one tick and low at the next. Ticks that find the pin steady have no effect.
- R8: In capture mode with the trigger enable set, a falling edge on `ext_trg_i` copies the count into the capture/reload pair and sets the trigger flag. The count itself does not change.
- R9: With the trigger enable clear, a trigger edge leaves the pair, the count and the trigger flag unchanged.
- R10: In reload mode with the trigger enable set, a trigger edge loads the count from the pair and sets the trigger flag.
- R11: In baud mode with internal counting, the count steps on every clock. Each step from FFFFh reloads the count from the pair and raises `baud_tick_o` for one clock. The overflow flag is never set in this mode.
- R12: Both flags stay set until a control write puts a 0 in their bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-clock machine-cycle tick |
| ext_cnt_i | input | 1 | External count pin (asynchronous) |
| ext_trg_i | input | 1 | External capture/reload trigger pin (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select |
| wr_data_i | input | 8 | Write data |
| ovf_flag_o | output | 1 | Overflow flag |
| trg_flag_o | output | 1 | External trigger flag |
| baud_tick_o | output | 1 | One-clock baud tick |
| count_o | output | 16 | Current count |
| rcap_o | output | 16 | Capture/reload pair |

## Verification
The counting path is exercised with a table of start values and tick counts. Short runs away from the top check plain stepping. Runs that start just below FFFFh separate a wrap to zero from a wrap that reloads. A long reload run starting near the top checks that reloading repeats and is not a one-time event. A stopped run shows that ticks are gated by run. Directed sequences then cover the following:
- Pin edges mixed with idle ticks, which tells edge counting apart from level counting.
- Triggers with the enable on and off, in both capture and reload modes.
- A baud run whose number of ticks over a fixed window fixes the reload period.
- Flag persistence followed by clearing through a control write.

// File: rtl/t16_pkg.sv
package t16_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;

  localparam logic [SEL_W-1:0] SEL_CNT_LO  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CNT_HI  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_RCAP_LO = 3'd2;
  localparam logic [SEL_W-1:0] SEL_RCAP_HI = 3'd3;
  localparam logic [SEL_W-1:0] SEL_CTRL    = 3'd4;

  localparam int B_RUN    = 0;
  localparam int B_EXTSEL = 1;
  localparam int B_TRGEN  = 2;
  localparam int B_RELOAD = 3;
  localparam int B_BAUD   = 4;
  localparam int B_TFLAG  = 6;
  localparam int B_OFLAG  = 7;

  typedef struct packed {
    logic run;
    logic ext_sel;
    logic trg_en;
    logic reload;
    logic baud;
  } t16_cfg_t;
endpackage

// File: rtl/t16_edge_det.sv
module t16_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic din_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              fall_q;
  logic              cur;

  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din_i};
      fall_q <= tick_i & prev_q & ~cur;
      if (tick_i) prev_q <= cur;
    end
  end

  assign fall_o = fall_q;
endmodule

// File: rtl/t16_ctrl.sv
module t16_ctrl
  import t16_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              ovf_set_i,
  input  logic              trg_set_i,
  output t16_cfg_t          cfg_o,
  output logic              ovf_flag_o,
  output logic              trg_flag_o
);
  t16_cfg_t cfg_q, cfg_n;
  logic     oflag_q, oflag_n;
  logic     tflag_q, tflag_n;
  logic     ctrl_wr;

  assign ctrl_wr = wr_en_i && (wr_sel_i == SEL_CTRL);

  always_comb begin
    cfg_n   = cfg_q;
    oflag_n = oflag_q;
    tflag_n = tflag_q;
    if (ctrl_wr) begin
      cfg_n.run     = wr_data_i[B_RUN];
      cfg_n.ext_sel = wr_data_i[B_EXTSEL];
      cfg_n.trg_en  = wr_data_i[B_TRGEN];
      cfg_n.reload  = wr_data_i[B_RELOAD];
      cfg_n.baud    = wr_data_i[B_BAUD];
      oflag_n       = wr_data_i[B_OFLAG];
      tflag_n       = wr_data_i[B_TFLAG];
    end
    if (ovf_set_i) oflag_n = 1'b1;
    if (trg_set_i) tflag_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      oflag_q <= 1'b0;
      tflag_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_n;
      oflag_q <= oflag_n;
      tflag_q <= tflag_n;
    end
  end

  assign cfg_o      = cfg_q;
  assign ovf_flag_o = oflag_q;
  assign trg_flag_o = tflag_q;
endmodule

// File: rtl/t16_counter.sv
module t16_counter
  import t16_pkg::*;
#(
  parameter int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  t16_cfg_t          cfg_i,
  input  logic              tick_i,
  input  logic              cnt_evt_i,
  input  logic              trg_evt_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  rcap_o,
  output logic              ovf_set_o,
  output logic              trg_set_o,
  output logic              baud_tick_o
);
  localparam int HI_LSB = CNT_W - BYTE_W;

  logic [CNT_W-1:0] count_q, count_n;
  logic [CNT_W-1:0] rcap_q, rcap_n;
  logic             btick_q;
  logic             step, at_top, wrap, trg_act, do_cap, do_trg_load;

  always_comb begin
    if (cfg_i.ext_sel)   step = cnt_evt_i;
    else if (cfg_i.baud) step = 1'b1;
    else                 step = tick_i;
    step = step & cfg_i.run;
  end

  assign at_top      = (count_q == {CNT_W{1'b1}});
  assign wrap        = step & at_top;
  assign trg_act     = trg_evt_i & cfg_i.trg_en;
  assign do_cap      = trg_act & ~cfg_i.baud & ~cfg_i.reload;
  assign do_trg_load = trg_act & ~cfg_i.baud & cfg_i.reload;

  always_comb begin
    count_n = count_q;
    if (step) begin
      if (at_top) count_n = (cfg_i.reload | cfg_i.baud) ? rcap_q : '0;
      else        count_n = count_q + 1'b1;
    end
    if (do_trg_load) count_n = rcap_q;
    if (wr_en_i && wr_sel_i == SEL_CNT_LO) count_n[BYTE_W-1:0]     = wr_data_i;
    if (wr_en_i && wr_sel_i == SEL_CNT_HI) count_n[CNT_W-1:HI_LSB] = wr_data_i;
  end

  always_comb begin
    rcap_n = rcap_q;
    if (wr_en_i && wr_sel_i == SEL_RCAP_LO) rcap_n[BYTE_W-1:0]     = wr_data_i;
    if (wr_en_i && wr_sel_i == SEL_RCAP_HI) rcap_n[CNT_W-1:HI_LSB] = wr_data_i;
    if (do_cap) rcap_n = count_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      rcap_q  <= '0;
      btick_q <= 1'b0;
    end else begin
      count_q <= count_n;
      rcap_q  <= rcap_n;
      btick_q <= wrap & cfg_i.baud;
    end
  end

  assign count_o     = count_q;
  assign rcap_o      = rcap_q;
  assign ovf_set_o   = wrap & ~cfg_i.baud;
  assign trg_set_o   = trg_act;
  assign baud_tick_o = btick_q;
endmodule

// File: rtl/t16_timer.sv
module t16_timer
  import t16_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              ext_cnt_i,
  input  logic              ext_trg_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              ovf_flag_o,
  output logic              trg_flag_o,
  output logic              baud_tick_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  rcap_o
);
  localparam int N_PINS = 2;

  logic [N_PINS-1:0] pin_raw;
  logic [N_PINS-1:0] pin_evt;
  t16_cfg_t          cfg;
  logic              ovf_set, trg_set;
  logic              cnt_evt, trg_evt;
  logic              ctrl_run, ctrl_baud, ctrl_reload;

  assign pin_raw = {ext_trg_i, ext_cnt_i};

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    t16_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .tick_i (tick_i),
      .din_i  (pin_raw[g]),
      .fall_o (pin_evt[g])
    );
  end

  assign cnt_evt     = pin_evt[0];
  assign trg_evt     = pin_evt[1];
  assign ctrl_run    = cfg.run;
  assign ctrl_baud   = cfg.baud;
  assign ctrl_reload = cfg.reload;

  t16_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .ovf_set_i  (ovf_set),
    .trg_set_i  (trg_set),
    .cfg_o      (cfg),
    .ovf_flag_o (ovf_flag_o),
    .trg_flag_o (trg_flag_o)
  );

  t16_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .cfg_i       (cfg),
    .tick_i      (tick_i),
    .cnt_evt_i   (cnt_evt),
    .trg_evt_i   (trg_evt),
    .count_o     (count_o),
    .rcap_o      (rcap_o),
    .ovf_set_o   (ovf_set),
    .trg_set_o   (trg_set),
    .baud_tick_o (baud_tick_o)
  );
endmodule

// File: rtl/t16_timer_chk.sv
module t16_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             run,
  input logic             baud,
  input logic             reload,
  input logic             trg_evt,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] rcap,
  input logic             ovf,
  input logic             trg,
  input logic             btick
);
  // R4
  run_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en && !trg_evt) |=> $stable(count));

  // R11
  baud_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (baud && !wr_en) |=> !$rose(ovf));

  // R11
  baud_from_top_chk: assert property (@(posedge clk) disable iff (rst)
    btick |-> ($past(count) == {CNT_W{1'b1}}));

  // R5 R6
  ovf_from_top_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ovf) && !$past(wr_en)) |-> ($past(count) == {CNT_W{1'b1}}));

  // R12
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((ovf || trg) && !wr_en) |=> ((ovf || !$past(ovf)) && (trg || !$past(trg))));

  // R8
  capture_val_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(trg) && !$past(wr_en) && !$past(baud) && !$past(reload)) |-> (rcap == $past(count)));
endmodule

bind t16_timer t16_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en_i),
  .run     (ctrl_run),
  .baud    (ctrl_baud),
  .reload  (ctrl_reload),
  .trg_evt (trg_evt),
  .count   (count_o),
  .rcap    (rcap_o),
  .ovf     (ovf_flag_o),
  .trg     (trg_flag_o),
  .btick   (baud_tick_o)
);

// File: tb/tb_t16_timer.sv
module tb_t16_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        ecnt = 1'b1;
  logic        etrg = 1'b1;
  logic        wen = 1'b0;
  logic [2:0]  wsel = 3'd0;
  logic [7:0]  wdat = 8'd0;
  logic        ovf, trg, btick;
  logic [15:0] count, rcap;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  t16_timer dut (
    .clk(clk), .rst(rst), .tick_i(tick), .ext_cnt_i(ecnt), .ext_trg_i(etrg),
    .wr_en_i(wen), .wr_sel_i(wsel), .wr_data_i(wdat),
    .ovf_flag_o(ovf), .trg_flag_o(trg), .baud_tick_o(btick),
    .count_o(count), .rcap_o(rcap)
  );

  // ctrl, count, rcap, ticks, expected count, expected overflow flag
  localparam logic [64:0] VEC [5] = '{
    {8'h01, 16'h0000, 16'h0000, 8'd5,  16'h0005, 1'b0},
    {8'h01, 16'hFFFE, 16'h0000, 8'd3,  16'h0001, 1'b1},
    {8'h09, 16'hFFFF, 16'h1234, 8'd1,  16'h1234, 1'b1},
    {8'h09, 16'hFFFE, 16'hFFF0, 8'd20, 16'hFFF2, 1'b1},
    {8'h08, 16'h00AA, 16'h0000, 8'd7,  16'h00AA, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wen = 1'b1; wsel = s; wdat = d;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic load(input logic [15:0] c, input logic [15:0] r);
    wr(3'd0, c[7:0]); wr(3'd1, c[15:8]);
    wr(3'd2, r[7:0]); wr(3'd3, r[15:8]);
  endtask

  // sel 0: count pin, 1: trigger pin
  task automatic pin_edge(input bit sel);
    if (sel) etrg = 1'b1; else ecnt = 1'b1;
    repeat (3) @(negedge clk);
    ticks(1);
    if (sel) etrg = 1'b0; else ecnt = 1'b0;
    repeat (3) @(negedge clk);
    ticks(1);
    repeat (2) @(negedge clk);
    if (sel) etrg = 1'b1; else ecnt = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 count", count, 16'h0000);
    chk("R1 rcap", rcap, 16'h0000);
    chk("R1 flags", {14'd0, ovf, trg}, 16'h0000);
    chk("R1 baud tick", {15'd0, btick}, 16'h0000);

    // R2 R3 R4 R5 R6: vector walk
    for (int v = 0; v < 5; v++) begin
      wr(3'd4, 8'h00);
      load(VEC[v][56:41], VEC[v][40:25]);
      chk("R2 count write", count, VEC[v][56:41]);
      wr(3'd4, VEC[v][64:57]);
      ticks(int'(VEC[v][24:17]));
      chk($sformatf("R3/R4/R5/R6 count vec%0d", v), count, VEC[v][16:1]);
      chk($sformatf("R5/R6 ovf vec%0d", v), {15'd0, ovf}, {15'd0, VEC[v][0]});
    end

    // R12: flag persists, then cleared by control write
    wr(3'd4, 8'h00);
    load(16'hFFFF, 16'h0000);
    wr(3'd4, 8'h01);
    ticks(1);
    ticks(3);
    chk("R12 ovf held", {15'd0, ovf}, 16'h0001);
    wr(3'd4, 8'h01);
    chk("R12 ovf cleared", {15'd0, ovf}, 16'h0000);

    // R7: external edges, idle ticks ignored
    wr(3'd4, 8'h00);
    load(16'h0000, 16'h0000);
    wr(3'd4, 8'h03);
    pin_edge(1'b0); pin_edge(1'b0);
    ticks(4);
    pin_edge(1'b0);
    chk("R7 external count", count, 16'h0003);

    // R8: capture with enable
    wr(3'd4, 8'h00);
    load(16'hABCD, 16'h0000);
    wr(3'd4, 8'h04);
    pin_edge(1'b1);
    chk("R8 captured", rcap, 16'hABCD);
    chk("R8 trig flag", {15'd0, trg}, 16'h0001);
    chk("R8 count kept", count, 16'hABCD);

    // R9: enable clear
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h11); wr(3'd1, 8'h11);
    pin_edge(1'b1);
    chk("R9 rcap kept", rcap, 16'hABCD);
    chk("R9 no flag", {15'd0, trg}, 16'h0000);

    // R10: trigger reload
    wr(3'd4, 8'h00);
    load(16'h0100, 16'h5A5A);
    wr(3'd4, 8'h0C);
    pin_edge(1'b1);
    chk("R10 reloaded", count, 16'h5A5A);
    chk("R10 trig flag", {15'd0, trg}, 16'h0001);

    // R11: baud mode, period 4 clocks
    wr(3'd4, 8'h00);
    load(16'hFFFC, 16'hFFFC);
    wr(3'd4, 8'h11);
    begin
      int nt = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (btick) nt++;
      end
      chk("R11 baud ticks", 16'(nt), 16'd10);
    end
    chk("R11 no ovf", {15'd0, ovf}, 16'h0000);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule